// File: doc/BRIEF.md
# Tiled Training Loop Sequencer

This block walks a tiled matrix-multiply engine through one layer pass of network training. It issues tile coordinates only; it moves no data and forms no addresses. A start pulse captures a mode select and four loop extents, each given as a number of tiles. The extents are output filters, input channels times kernel positions, pixels, and batch. The block then presents one step per cycle while the engine holds ready high. Each step carries four tile indices and two accumulator strobes. The first strobe tells the engine to clear its partial sum. The last strobe tells it that the partial sum is complete and may be quantized and emitted.

The four modes share one stack of four nested counters. Each mode assigns the loop dimensions to the counter levels in its own order, and that order decides which level is the reduction. In the gradient mode the reduction spans two levels, pixels and batch, because the gradient sums over both. The fully-connected mode has no pixel loop, so its pixel extent is ignored and held at one. After the final step is accepted, a one-cycle done pulse follows.

Top module: `tile_loop_seq`

## Requirements
- R1: After reset, step_valid, acc_first, acc_last and seq_done are 0 and all four tile indices are 0.
- R2: A start pulse while idle captures mode and the four extents, and step_valid rises on the next cycle with all indices 0. A start pulse while a pass is running is ignored, and the running sequence continues unchanged.
- R3: Mode 0 (convolution forward) orders the loops, outer to inner, as filter, pixel, batch, channel. acc_first marks channel index 0 and acc_last marks the final channel index.
- R4: Mode 1 (convolution backward) orders the loops as channel, pixel, batch, filter. acc_first and acc_last mark the first and final filter index.
- R5: Mode 2 (gradient) orders the loops as filter, channel, batch, pixel. acc_first is set only where both the pixel and batch indices are 0. acc_last is set only where both are at their final values.
- R6: Mode 3 (fully-connected forward) orders the loops as filter, batch, channel. The pixel extent input is ignored and tile_p stays 0. acc_first and acc_last mark the first and final channel index.
- R7: An extent of 0 is treated as 1. When every reduction extent is 1, acc_first and acc_last are both set on every step.
- R8: While step_valid is high and ready is low, the indices, strobes and step_valid hold their values. A step advances only on a cycle where ready is high.
- R9: seq_done is high for exactly one cycle, the cycle after the final step is accepted. step_valid is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (honoured only while idle) |
| mode | input | 2 | 0 conv forward, 1 conv backward, 2 gradient, 3 fully-connected forward |
| cnt_f | input | CW | Filter extent in tiles |
| cnt_c | input | CW | Channel-times-kernel extent in tiles |
| cnt_p | input | CW | Pixel extent in tiles |
| cnt_b | input | CW | Batch extent in tiles |
| ready | input | 1 | Engine accepts the current step |
| step_valid | output | 1 | A step is being presented |
| tile_f | output | CW | Filter tile index |
| tile_c | output | CW | Channel tile index |
| tile_p | output | CW | Pixel tile index |
| tile_b | output | CW | Batch tile index |
| acc_first | output | 1 | First partial of an output tile |
| acc_last | output | 1 | Last partial of an output tile |
| seq_done | output | 1 | One-cycle pulse after the final step |

## Verification
A level-to-dimension mapping that is wrong for a mode shows up on the first step that wraps the innermost counter. That is at most one reduction extent of accepted steps after start. The scoreboard sees it there as an index out of order. A reduction boundary in the wrong place appears as a first or last strobe on the wrong step within the first output tile. The gradient mode's two-level boundary is the case most likely to be misplaced. A broken carry chain or a missed hold under backpressure shows up as a repeated or skipped coordinate on the next accepted step. A wrong final-step term shows up as an early or late done pulse against the empty queue.

// File: rtl/tls_pkg.sv
package tls_pkg;
   typedef enum logic [1:0] {
      M_CONV_FWD  = 2'd0,
      M_CONV_BWD  = 2'd1,
      M_CONV_GRAD = 2'd2,
      M_FC_FWD    = 2'd3
   } tls_mode_e;

   localparam int NLVL = 4;
   localparam int NDIM = 4;
   // dimension identifiers
   localparam logic [1:0] D_F = 2'd0;
   localparam logic [1:0] D_C = 2'd1;
   localparam logic [1:0] D_P = 2'd2;
   localparam logic [1:0] D_B = 2'd3;

   // packed order word: bits [2k+1:2k] name the dimension on level k (level 0 innermost)
   function automatic logic [2*NLVL-1:0] order_of(tls_mode_e m);
      case (m)
         M_CONV_BWD:  order_of = {D_C, D_P, D_B, D_F};
         M_CONV_GRAD: order_of = {D_F, D_C, D_B, D_P};
         default:     order_of = {D_F, D_P, D_B, D_C};
      endcase
   endfunction
endpackage

// File: rtl/tls_order_map.sv
module tls_order_map
   import tls_pkg::*;
#(
   parameter int CW = 8
) (
   input  tls_mode_e                  mode,
   input  logic [NDIM-1:0][CW-1:0]    dim_cnt,
   input  logic [NLVL-1:0][CW-1:0]    lvl_val,
   output logic [NLVL-1:0][CW-1:0]    lvl_lim,
   output logic [NDIM-1:0][CW-1:0]    dim_idx
);
   logic [2*NLVL-1:0] ord;

   always_comb begin
      ord     = order_of(mode);
      dim_idx = '0;
      for (int k = 0; k < NLVL; k++) begin
         lvl_lim[k]                = dim_cnt[ord[2*k +: 2]];
         dim_idx[ord[2*k +: 2]]    = lvl_val[k];
      end
   end
endmodule

// File: rtl/tls_level_ctr.sv
module tls_level_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic [CW-1:0] lim,
   output logic [CW-1:0] val,
   output logic          wrap
);
   assign wrap = (val == lim - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val <= '0;
      else if (clr)  val <= '0;
      else if (inc)  val <= wrap ? '0 : val + 1'b1;
   end

   // R7
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lim != '0) |-> (val < lim));
endmodule

// File: rtl/tile_loop_seq.sv
module tile_loop_seq
   import tls_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] cnt_f,
   input  logic [CW-1:0] cnt_c,
   input  logic [CW-1:0] cnt_p,
   input  logic [CW-1:0] cnt_b,
   input  logic          ready,
   output logic          step_valid,
   output logic [CW-1:0] tile_f,
   output logic [CW-1:0] tile_c,
   output logic [CW-1:0] tile_p,
   output logic [CW-1:0] tile_b,
   output logic          acc_first,
   output logic          acc_last,
   output logic          seq_done
);
   localparam logic [CW-1:0] ONE = CW'(1);

   if (CW < 2) begin : g_bad_cw
      $error("tile_loop_seq: CW must be at least 2");
   end

   logic                      busy, done_q;
   tls_mode_e                 mode_q;
   logic [NDIM-1:0][CW-1:0]   cnt_q;
   logic [NLVL-1:0][CW-1:0]   lvl_val, lvl_lim;
   logic [NDIM-1:0][CW-1:0]   dim_idx;
   logic [NLVL-1:0]           wrap, inc;
   logic                      start_ok, fire, final_step;

   assign start_ok   = start && !busy;
   assign fire       = busy && ready;
   assign final_step = fire && (&wrap);

   function automatic logic [CW-1:0] clamp1(logic [CW-1:0] v);
      return (v == '0) ? ONE : v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done_q <= 1'b0;
         mode_q <= M_CONV_FWD;
         cnt_q  <= {NDIM{ONE}};
      end else begin
         done_q <= final_step;
         if (start_ok) begin
            busy       <= 1'b1;
            mode_q     <= tls_mode_e'(mode);
            cnt_q[D_F] <= clamp1(cnt_f);
            cnt_q[D_C] <= clamp1(cnt_c);
            cnt_q[D_P] <= (tls_mode_e'(mode) == M_FC_FWD) ? ONE : clamp1(cnt_p);
            cnt_q[D_B] <= clamp1(cnt_b);
         end else if (final_step) begin
            busy <= 1'b0;
         end
      end
   end

   tls_order_map #(.CW(CW)) u_map (
      .mode    (mode_q),
      .dim_cnt (cnt_q),
      .lvl_val (lvl_val),
      .lvl_lim (lvl_lim),
      .dim_idx (dim_idx)
   );

   for (genvar k = 0; k < NLVL; k++) begin : g_lvl
      if (k == 0) begin : g_in
         assign inc[k] = fire;
      end else begin : g_carry
         assign inc[k] = inc[k-1] && wrap[k-1];
      end
      tls_level_ctr #(.CW(CW)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (start_ok),
         .inc   (inc[k]),
         .lim   (lvl_lim[k]),
         .val   (lvl_val[k]),
         .wrap  (wrap[k])
      );
   end

   logic red_first, red_last;
   always_comb begin
      if (mode_q == M_CONV_GRAD) begin
         red_first = (lvl_val[0] == '0) && (lvl_val[1] == '0);
         red_last  = wrap[0] && wrap[1];
      end else begin
         red_first = (lvl_val[0] == '0);
         red_last  = wrap[0];
      end
   end

   assign step_valid = busy;
   assign tile_f     = dim_idx[D_F];
   assign tile_c     = dim_idx[D_C];
   assign tile_p     = dim_idx[D_P];
   assign tile_b     = dim_idx[D_B];
   assign acc_first  = busy && red_first;
   assign acc_last   = busy && red_last;
   assign seq_done   = done_q;

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !ready) |=> (step_valid && $stable(tile_f) && $stable(tile_c)
                                  && $stable(tile_p) && $stable(tile_b)
                                  && $stable(acc_first) && $stable(acc_last)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !step_valid);
   // R5
   next_tile_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && ready && acc_last) |=> (!step_valid || acc_first));
   // R6
   fc_pixel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && mode_q == M_FC_FWD) |-> (tile_p == '0));
   // R2
   start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_valid) |-> (tile_f == '0 && tile_c == '0 && tile_p == '0 && tile_b == '0));
endmodule

// File: tb/sim_tile_loop_seq.sv
module sim_tile_loop_seq;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [CW-1:0] cnt_f = '0, cnt_c = '0, cnt_p = '0, cnt_b = '0;
   logic          ready = 1'b0;
   logic          step_valid, acc_first, acc_last, seq_done;
   logic [CW-1:0] tile_f, tile_c, tile_p, tile_b;

   always #10 clk = ~clk;

   tile_loop_seq #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .cnt_f(cnt_f), .cnt_c(cnt_c), .cnt_p(cnt_p), .cnt_b(cnt_b),
      .ready(ready), .step_valid(step_valid),
      .tile_f(tile_f), .tile_c(tile_c), .tile_p(tile_p), .tile_b(tile_b),
      .acc_first(acc_first), .acc_last(acc_last), .seq_done(seq_done)
   );

   typedef struct {
      int f, c, p, b;
      bit fi, la;
   } item_t;

   item_t q[$];
   string cur_tag = "R1";
   int    errors = 0, checks = 0, dones = 0, cycles = 0;
   bit    stall_en = 1'b0, mon_on = 1'b0, exp_done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   bit    held = 1'b0;
   int    hf, hc, hp, hb;
   bit    hfi, hla;

   task automatic chk(string tag, bit ok, string act, string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %s expected %s", tag, act, exp);
      end
   endtask

   task automatic push(int f, int c, int p, int b, bit fi, bit la);
      item_t it;
      it.f = f; it.c = c; it.p = p; it.b = b; it.fi = fi; it.la = la;
      q.push_back(it);
   endtask

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   // expected sequence written directly from the per-mode loop orders
   task automatic gen(int m, int nf, int nc, int np, int nb);
      nf = eff(nf); nc = eff(nc); np = eff(np); nb = eff(nb);
      case (m)
         0: for (int f = 0; f < nf; f++) for (int p = 0; p < np; p++)
               for (int b = 0; b < nb; b++) for (int c = 0; c < nc; c++)
                  push(f, c, p, b, c == 0, c == nc-1);
         1: for (int c = 0; c < nc; c++) for (int p = 0; p < np; p++)
               for (int b = 0; b < nb; b++) for (int f = 0; f < nf; f++)
                  push(f, c, p, b, f == 0, f == nf-1);
         2: for (int f = 0; f < nf; f++) for (int c = 0; c < nc; c++)
               for (int b = 0; b < nb; b++) for (int p = 0; p < np; p++)
                  push(f, c, p, b, p == 0 && b == 0, p == np-1 && b == nb-1);
         default: for (int f = 0; f < nf; f++) for (int b = 0; b < nb; b++)
               for (int c = 0; c < nc; c++)
                  push(f, c, 0, b, c == 0, c == nc-1);
      endcase
   endtask

   task automatic run_job(string tag, int m, int nf, int nc, int np, int nb,
                          bit stall, bit poke);
      int d0;
      cur_tag  = tag;
      stall_en = stall;
      gen(m, nf, nc, np, nb);
      d0 = dones;
      @(negedge clk);
      mode = 2'(m); cnt_f = CW'(nf); cnt_c = CW'(nc); cnt_p = CW'(np); cnt_b = CW'(nb);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (3) @(negedge clk);
         mode = 2'd3; cnt_f = 8'd7; cnt_c = 8'd7; cnt_b = 8'd7;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (dones == d0 + 1);
      repeat (3) @(negedge clk);
      chk(tag, q.size() == 0, $sformatf("%0d left", q.size()), "0 left");
   endtask

   // monitor: pops and compares accepted steps, checks stall hold and done timing
   always @(negedge clk) begin
      bit r;
      item_t e;
      if (mon_on) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r = stall_en ? (lfsr[1] | lfsr[4]) : 1'b1;
         if (held) begin
            chk("R8", step_valid && tile_f == hf && tile_c == hc && tile_p == hp &&
                tile_b == hb && acc_first == hfi && acc_last == hla,
                $sformatf("v%0d %0d/%0d/%0d/%0d", step_valid, tile_f, tile_c, tile_p, tile_b),
                $sformatf("v1 %0d/%0d/%0d/%0d", hf, hc, hp, hb));
            held = 1'b0;
         end
         if (exp_done || seq_done) begin
            chk("R9", seq_done == exp_done && !step_valid,
                $sformatf("done=%0d valid=%0d", seq_done, step_valid),
                $sformatf("done=%0d valid=0", exp_done));
            if (seq_done) dones++;
            exp_done = 1'b0;
         end
         if (step_valid && r) begin
            if (q.size() == 0) begin
               chk(cur_tag, 1'b0, "extra step", "no step");
            end else begin
               e = q.pop_front();
               chk(cur_tag, tile_f == e.f && tile_c == e.c && tile_p == e.p &&
                   tile_b == e.b && acc_first == e.fi && acc_last == e.la,
                   $sformatf("%0d/%0d/%0d/%0d f%0d l%0d", tile_f, tile_c, tile_p, tile_b,
                             acc_first, acc_last),
                   $sformatf("%0d/%0d/%0d/%0d f%0d l%0d", e.f, e.c, e.p, e.b, e.fi, e.la));
               if (q.size() == 0) exp_done = 1'b1;
            end
         end else if (step_valid) begin
            held = 1'b1;
            hf = tile_f; hc = tile_c; hp = tile_p; hb = tile_b;
            hfi = acc_first; hla = acc_last;
         end
         ready <= r;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", !step_valid && !seq_done && !acc_first && !acc_last,
          $sformatf("v%0d d%0d f%0d l%0d", step_valid, seq_done, acc_first, acc_last), "all 0");
      chk("R1", tile_f == 0 && tile_c == 0 && tile_p == 0 && tile_b == 0,
          $sformatf("%0d/%0d/%0d/%0d", tile_f, tile_c, tile_p, tile_b), "0/0/0/0");
      mon_on = 1'b1;
      run_job("R3", 0, 2, 3, 2, 2, 1'b0, 1'b0);
      run_job("R4", 1, 3, 2, 2, 2, 1'b1, 1'b0);
      run_job("R5", 2, 2, 2, 3, 2, 1'b1, 1'b0);
      run_job("R6", 3, 2, 3, 5, 2, 1'b1, 1'b0);
      run_job("R7", 0, 0, 1, 2, 3, 1'b0, 1'b0);
      run_job("R7", 2, 3, 2, 1, 1, 1'b1, 1'b0);
      run_job("R2", 1, 2, 3, 2, 2, 1'b1, 1'b1);
      run_job("R5", 2, 1, 3, 2, 3, 1'b0, 1'b0);
      mon_on = 1'b0;
      @(negedge clk);
      chk("R9", !step_valid && !seq_done,
          $sformatf("v%0d d%0d", step_valid, seq_done), "v0 d0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule